// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block produces the system reset for a board or chip region from two conditions: a digital "supply below threshold" flag delivered by an external comparator, and an active-low manual reset line that may come straight from a push button. While either condition is active the reset is held. Once both have cleared, the reset stays held for a fixed stretch of clock ticks before it lets go. A new trigger during the stretch starts the count again.

The manual line passes through a synchronizer and a debouncer. A new level on it counts only after it has held steady for a set number of ticks, so contact bounce and short glitches do not reach the reset. The supply flag is synchronized but not filtered.

Two outputs are given: an active-low reset and an active-high reset that is always its exact complement. Each comes from its own flop. The block has no watchdog input. A watchdog can reset the system only if its output is wired into the manual reset line. The block runs on a slow timebase. The stretch and debounce lengths are parameters in ticks of that clock.

Top module: `supply_reset_gen`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is 0. With both triggers idle it stays 0 for STRETCH_TICKS-1 edges after `rst_n` rises, and it reads 1 after the STRETCH_TICKS-th edge.
- R2: When `supply_low_i` becomes 1, `rst_out_n` reads 0 after the third rising clock edge: two synchronizer stages, then the output flop.
- R3: When `supply_low_i` returns to 0 and the manual line is idle, `rst_out_n` stays 0 for STRETCH_TICKS+1 edges and reads 1 after edge STRETCH_TICKS+2.
- R4: When `man_rst_n_i` goes low and stays low, `rst_out_n` reads 1 after edge DEB_TICKS+2 and reads 0 after edge DEB_TICKS+3.
- R5: When `man_rst_n_i` returns high with the supply flag clear, `rst_out_n` reads 1 after edge STRETCH_TICKS+DEB_TICKS+2 and reads 0 one edge earlier.
- R6: A low pulse on `man_rst_n_i` shorter than DEB_TICKS cycles leaves `rst_out_n` at 1, and so does bounce made of such pulses.
- R7: A trigger that comes back during the stretch restarts it. The release then comes STRETCH_TICKS+2 edges after that trigger clears, and not at the earlier scheduled time.
- R8: `rst_out` is the exact complement of `rst_out_n` at every clock cycle.
- R9: The reset stays held while any trigger is active. Clearing one trigger while the other is still active does not start the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timebase clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| supply_low_i | input | 1 | Supply-below-threshold flag, 1 = low supply (asynchronous) |
| man_rst_n_i | input | 1 | Raw manual reset, 0 = reset requested (asynchronous, may bounce) |
| rst_out_n | output | 1 | Active-low system reset |
| rst_out | output | 1 | Active-high system reset, complement of rst_out_n |

## Verification
The stretch function is driven in several ways:
- The supply flag and the manual line are each used alone. This separates the synchronizer delay from the debounce delay, in both the assertion and the release edge counts.
- A short manual pulse and a train of bounce pulses, both below the debounce length, must leave the outputs untouched. A later steady low must still assert the reset. Together these show the filter rejecting glitches while still accepting a real press.
- A trigger pulse in the middle of a stretch must move the release to its later time.
- The two triggers overlap and are cleared in turn. This shows the hold comes from either condition and is not tied to the most recent one.

// File: rtl/srg_pkg.sv
// Package srg_pkg: types shared by the supply reset generator.
// Assumes: bit 1 = supply flag (active high), bit 0 = manual line (active low).
package srg_pkg;

    typedef struct packed {
        logic supply_low;
        logic man_n;
    } srg_trig_t;

    // Idle level of the trigger bundle: supply fine, button released.
    localparam srg_trig_t SRG_IDLE = '{supply_low: 1'b0, man_n: 1'b1};

endpackage

// File: rtl/srg_sync.sv
// Module srg_sync: multi-stage synchronizer for a bundle of asynchronous bits.
// Assumes STAGES >= 1. Every stage resets to RST_VAL, so the bundle reads idle
// right after power-on.
module srg_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/srg_debounce.sv
// Module srg_debounce: accepts a new input level only after it has held for
// DEB_TICKS consecutive clocks.
// Assumes a synchronized input and DEB_TICKS >= 2. Resets to the released level (1).
module srg_debounce #(
    parameter int DEB_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic stable
);

    localparam int CW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          stable_q;

    // Count consecutive cycles of disagreement; adopt the new level when the count is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b1;
            cnt_q    <= '0;
        end else if (raw == stable_q) begin
            cnt_q    <= '0;
        end else if (cnt_q == LAST) begin
            stable_q <= raw;
            cnt_q    <= '0;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    assign stable = stable_q;

    // R6: the accepted level changes only after a full disagreement count.
    p_deb_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stable_q) |-> $past(cnt_q) == LAST);

    // R6: a new level is adopted only when the input disagreed on the edge before.
    p_deb_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stable_q) |-> $past(raw) != $past(stable_q));

endmodule

// File: rtl/srg_stretch.sv
// Module srg_stretch: holds reset while trig is high and for STRETCH_TICKS
// clocks after it drops. A new trigger restarts the count.
// Assumes STRETCH_TICKS >= 2. Power-on reset counts as a trigger. The two
// outputs are separate flops with opposite polarity.
module srg_stretch #(
    parameter int STRETCH_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic hold,
    output logic hold_n
);

    localparam int CW = (STRETCH_TICKS > 1) ? $clog2(STRETCH_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STRETCH_TICKS - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          hold_q, hold_n_q, hold_d;

    // Next-state rule: trigger re-arms, otherwise count down the stretch.
    always_comb begin
        hold_d = hold_q;
        cnt_d  = cnt_q;
        if (trig) begin
            hold_d = 1'b1;
            cnt_d  = '0;
        end else if (hold_q) begin
            if (cnt_q == LAST) begin
                hold_d = 1'b0;
                cnt_d  = '0;
            end else begin
                cnt_d  = cnt_q + 1'b1;
            end
        end
    end

    // State and output flops; reset enters the held state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= 1'b1;
            hold_n_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            hold_q   <= hold_d;
            hold_n_q <= ~hold_d;
            cnt_q    <= cnt_d;
        end
    end

    assign hold   = hold_q;
    assign hold_n = hold_n_q;

    // R9: an active trigger always leaves reset held on the next edge.
    p_trig_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> hold_q);

    // R3: release happens only after a quiet cycle with the count full.
    p_release_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_q) |-> (!$past(trig) && $past(cnt_q) == LAST));

    // R3: the stretch count never passes its limit.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R8: the two output flops always disagree.
    p_complement_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q != hold_n_q);

endmodule

// File: rtl/supply_reset_gen.sv
// Module supply_reset_gen: system reset from a supply-low flag and a debounced
// manual reset, with a post-release stretch and complementary outputs.
// Assumes both inputs are asynchronous to clk and that clk is a slow timebase.
// The block takes no watchdog input.
module supply_reset_gen #(
    parameter int STRETCH_TICKS = 200,
    parameter int DEB_TICKS     = 20,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low_i,
    input  logic man_rst_n_i,
    output logic rst_out_n,
    output logic rst_out
);

    import srg_pkg::*;

    srg_trig_t raw_in, synced;
    logic      man_stable;
    logic      trig;

    assign raw_in.supply_low = supply_low_i;
    assign raw_in.man_n      = man_rst_n_i;

    srg_sync #(
        .WIDTH   ($bits(srg_trig_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SRG_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (synced)
    );

    srg_debounce #(
        .DEB_TICKS (DEB_TICKS)
    ) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (synced.man_n),
        .stable (man_stable)
    );

    // Either condition requests reset.
    assign trig = synced.supply_low | ~man_stable;

    srg_stretch #(
        .STRETCH_TICKS (STRETCH_TICKS)
    ) u_str (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig),
        .hold   (rst_out),
        .hold_n (rst_out_n)
    );

    // R2: a synchronized supply-low flag keeps the reset asserted on the next edge.
    p_supply_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        synced.supply_low |=> !rst_out_n);

endmodule

// File: tb/sim_supply_reset_gen.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected output values tagged with a
// cycle number, and a monitor compares them at the falling edge of that cycle.
module sim_supply_reset_gen;

    localparam int S = 20;
    localparam int D = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low_i = 1'b0;
    logic man_rst_n_i = 1'b1;
    logic rst_out_n, rst_out;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    supply_reset_gen #(
        .STRETCH_TICKS (S),
        .DEB_TICKS     (D),
        .SYNC_STAGES   (2)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_low_i (supply_low_i),
        .man_rst_n_i  (man_rst_n_i),
        .rst_out_n    (rst_out_n),
        .rst_out      (rst_out)
    );

    // Push the expected rst_out_n value for the cycle off edges from now.
    task automatic expect_at(int off, bit v, string tag);
        exp_t e;
        e.at = cyc + off; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Monitor: compare due items at each falling edge, plus the complement (R8).
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                n_chk++;
                if (rst_out_n !== sb[i].val) begin
                    n_bad++;
                    $display("FAIL %s cyc %0d: rst_out_n=%b expected %b",
                             sb[i].tag, cyc, rst_out_n, sb[i].val);
                end
                sb.delete(i);
            end
        end
        if (cyc > 0) begin
            n_chk++;
            if (rst_out !== ~rst_out_n) begin
                n_bad++;
                $display("FAIL R8 cyc %0d: rst_out=%b expected %b", cyc, rst_out, ~rst_out_n);
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        tick(1);
        // R1: held during power-on reset.
        expect_at(1, 1'b0, "R1");
        expect_at(2, 1'b0, "R1");
        tick(3);
        rst_n = 1'b1;
        // R1: released after the stretch.
        expect_at(S - 1, 1'b0, "R1");
        expect_at(S, 1'b1, "R1");
        tick(S + 5);

        // R2 / R3: supply flag alone.
        supply_low_i = 1'b1;
        expect_at(2, 1'b1, "R2");
        expect_at(3, 1'b0, "R2");
        tick(10);
        supply_low_i = 1'b0;
        expect_at(S + 1, 1'b0, "R3");
        expect_at(S + 2, 1'b1, "R3");
        tick(S + 5);

        // R4 / R5: steady manual press.
        man_rst_n_i = 1'b0;
        expect_at(D + 2, 1'b1, "R4");
        expect_at(D + 3, 1'b0, "R4");
        tick(D + 10);
        man_rst_n_i = 1'b1;
        expect_at(S + D + 1, 1'b0, "R5");
        expect_at(S + D + 2, 1'b1, "R5");
        tick(S + D + 5);

        // R6: short glitch is ignored.
        for (int k = 1; k <= D + 6; k++) expect_at(k, 1'b1, "R6");
        man_rst_n_i = 1'b0;
        tick(D - 2);
        man_rst_n_i = 1'b1;
        tick(D + 10);

        // R6: bounce shorter than the debounce length is ignored.
        for (int k = 1; k <= 36 + D; k++) expect_at(k, 1'b1, "R6");
        for (int b = 0; b < 6; b++) begin
            man_rst_n_i = 1'b0;
            tick(3);
            man_rst_n_i = 1'b1;
            tick(3);
        end
        // R4: a steady press after the bounce is still accepted.
        man_rst_n_i = 1'b0;
        expect_at(D + 2, 1'b1, "R4");
        expect_at(D + 3, 1'b0, "R4");
        tick(D + 5);
        man_rst_n_i = 1'b1;
        expect_at(S + D + 2, 1'b1, "R5");
        tick(S + D + 5);

        // R7: a trigger during the stretch restarts it.
        supply_low_i = 1'b1;
        tick(5);
        supply_low_i = 1'b0;
        tick(10);
        supply_low_i = 1'b1;
        tick(1);
        supply_low_i = 1'b0;
        expect_at(S - 9, 1'b0, "R7");
        expect_at(S + 1, 1'b0, "R7");
        expect_at(S + 2, 1'b1, "R7");
        tick(S + 5);

        // R9: overlapping triggers, supply clears first.
        supply_low_i = 1'b1;
        tick(3);
        man_rst_n_i = 1'b0;
        tick(D + 5);
        supply_low_i = 1'b0;
        expect_at(S + 2, 1'b0, "R9");
        expect_at(S + 4, 1'b0, "R9");
        tick(S + 10);
        man_rst_n_i = 1'b1;
        expect_at(S + D + 1, 1'b0, "R9");
        expect_at(S + D + 2, 1'b1, "R9");
        tick(S + D + 5);

        while (sb.size() != 0) tick(1);
        done = 1'b1;
        finish_run();
    end

endmodule